// File: doc/BRIEF.md
# Microcoded Multicycle Control Sequencer

This block produces the datapath control bits of a five-step multicycle processor from a small microprogram, not from hand-written next-state logic. A 4-bit micro-address register selects one word of a microcode ROM. The ROM is built at elaboration time from a function. Each word holds a 16-bit control field and a 2-bit sequencing field. The control field drives the outputs directly, so a line is high only when the current word asserts it.

The sequencing field chooses the next micro-address in one of four ways. It can step to the following word. It can return to the fetch word. It can branch through one of two dispatch tables, both indexed by the 6-bit opcode. The first table is used after decode and splits the instruction classes. The second is used after the memory-address step and separates loads from stores. An opcode that has no entry in the table being consulted sends the sequencer back to fetch and sets a sticky illegal-opcode flag.

The named microinstructions are FETCH (0), DECODE (1), MEM_ADDR (2), LOAD_MEM (3), LOAD_WB (4), STORE_MEM (5), R_EXEC (6), R_WB (7) and BRANCH (8). The named transitions are:
- FETCH→DECODE (step)
- DECODE→R_EXEC, MEM_ADDR or BRANCH (table 1), or →FETCH on a miss
- MEM_ADDR→LOAD_MEM or STORE_MEM (table 2), or →FETCH on a miss
- LOAD_MEM→LOAD_WB (step)
- R_EXEC→R_WB (step)
- LOAD_WB, STORE_MEM, R_WB and BRANCH→FETCH (fetch)

Top module: `ucode_seq`

## Requirements
- R1: A synchronous reset, while `rst` is high at a rising edge, sets `uaddr` to 0 and clears `illegal_op`. `ctrl` then shows the FETCH word.
- R2: `ctrl` bit layout, from bit 15 down to bit 0:
  - bit 15: pc_write
  - bit 14: pc_write_cond
  - bit 13: addr_from_alu
  - bit 12: mem_read
  - bit 11: mem_write
  - bit 10: ir_write
  - bit 9: wb_from_mem
  - bits 8:7: pc_select
  - bits 6:5: alu_mode
  - bits 4:3: alu_b_select
  - bit 2: alu_a_select
  - bit 1: reg_write
  - bit 0: dest_is_rd

  The FETCH word is 0x9408: pc_write, mem_read and ir_write high, with alu_b_select = 01.
- R3: `ctrl` equals the word of the current micro-address, and every bit not listed here is 0:
  - DECODE = 0x0018
  - MEM_ADDR = 0x0014
  - LOAD_MEM = 0x3000
  - LOAD_WB = 0x0202
  - STORE_MEM = 0x2800
  - R_EXEC = 0x0044
  - R_WB = 0x0003
  - BRANCH = 0x40A4
- R4: Sequencing field codes are 00 = fetch, 01 = table 1, 10 = table 2 and 11 = step. A step word moves `uaddr` to the current address plus one at the next edge.
- R5: A fetch word moves `uaddr` to 0 at the next edge.
- R6: Table 1 maps opcode 0x00 to 6, opcodes 0x23 and 0x2B to 2, and opcode 0x04 to 8.
- R7: Table 2 maps opcode 0x23 to 3 and opcode 0x2B to 5.
- R8: A dispatch on an opcode with no entry in that table sends `uaddr` to 0 and sets `illegal_op`. `illegal_op` then stays high until reset.
- R9: Starting from 0, a legal instruction returns to 0 after a fixed number of cycles:
  - 0x23: 5 cycles
  - 0x2B: 4 cycles
  - 0x00: 4 cycles
  - 0x04: 3 cycles
  - any unmapped opcode: 2 cycles

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the instruction register |
| ctrl | output | 16 | Datapath control bits of the current microinstruction |
| uaddr | output | 4 | Current micro-address |
| illegal_op | output | 1 | Sticky flag: a dispatch found no table entry |

## Verification
The properties assume that `opcode` is stable across each rising edge. They also assume that reset is applied before the first instruction. Apart from that, they accept any opcode value, including values that change partway through an instruction.

The stimulus drives the opcode on falling edges only. It resets the block before each of the 64 opcodes. In one directed case it changes the opcode between decode and the memory-address step, so that table 2 misses.

// File: rtl/ucode_pkg.sv
package ucode_pkg;

    localparam int OPW = 6;
    localparam int UAW = 4;
    localparam int CW  = 16;

    localparam logic [OPW-1:0] OP_RTYPE = 6'h00;
    localparam logic [OPW-1:0] OP_LOAD  = 6'h23;
    localparam logic [OPW-1:0] OP_STORE = 6'h2B;
    localparam logic [OPW-1:0] OP_BEQ   = 6'h04;

    typedef enum logic [1:0] {
        SQ_FETCH = 2'b00,
        SQ_DISP1 = 2'b01,
        SQ_DISP2 = 2'b10,
        SQ_NEXT  = 2'b11
    } seq_mode_e;

    typedef enum logic [UAW-1:0] {
        U_FETCH   = 4'd0,
        U_DECODE  = 4'd1,
        U_MADDR   = 4'd2,
        U_LDMEM   = 4'd3,
        U_LDWB    = 4'd4,
        U_STMEM   = 4'd5,
        U_REXEC   = 4'd6,
        U_RWB     = 4'd7,
        U_BRANCH  = 4'd8
    } ustep_e;

    typedef struct packed {
        logic       pc_write;
        logic       pc_write_cond;
        logic       addr_from_alu;
        logic       mem_read;
        logic       mem_write;
        logic       ir_write;
        logic       wb_from_mem;
        logic [1:0] pc_select;
        logic [1:0] alu_mode;
        logic [1:0] alu_b_select;
        logic       alu_a_select;
        logic       reg_write;
        logic       dest_is_rd;
    } ctrl_t;

    typedef struct packed {
        ctrl_t     ctrl;
        seq_mode_e seq;
    } uword_t;

    // Microprogram contents, one word per micro-address.
    function automatic uword_t uword_at(logic [UAW-1:0] a);
        uword_t w;
        w.ctrl = '0;
        w.seq  = SQ_FETCH;
        case (a)
            4'd0: begin
                w.ctrl.pc_write     = 1'b1;
                w.ctrl.mem_read     = 1'b1;
                w.ctrl.ir_write     = 1'b1;
                w.ctrl.alu_b_select = 2'b01;
                w.seq               = SQ_NEXT;
            end
            4'd1: begin
                w.ctrl.alu_b_select = 2'b11;
                w.seq               = SQ_DISP1;
            end
            4'd2: begin
                w.ctrl.alu_a_select = 1'b1;
                w.ctrl.alu_b_select = 2'b10;
                w.seq               = SQ_DISP2;
            end
            4'd3: begin
                w.ctrl.addr_from_alu = 1'b1;
                w.ctrl.mem_read      = 1'b1;
                w.seq                = SQ_NEXT;
            end
            4'd4: begin
                w.ctrl.reg_write   = 1'b1;
                w.ctrl.wb_from_mem = 1'b1;
            end
            4'd5: begin
                w.ctrl.addr_from_alu = 1'b1;
                w.ctrl.mem_write     = 1'b1;
            end
            4'd6: begin
                w.ctrl.alu_a_select = 1'b1;
                w.ctrl.alu_mode     = 2'b10;
                w.seq               = SQ_NEXT;
            end
            4'd7: begin
                w.ctrl.reg_write  = 1'b1;
                w.ctrl.dest_is_rd = 1'b1;
            end
            4'd8: begin
                w.ctrl.pc_write_cond = 1'b1;
                w.ctrl.alu_a_select  = 1'b1;
                w.ctrl.alu_mode      = 2'b01;
                w.ctrl.pc_select     = 2'b01;
            end
            default: begin
                w.ctrl = '0;
                w.seq  = SQ_FETCH;
            end
        endcase
        return w;
    endfunction

endpackage

// File: rtl/ucode_rom.sv
module ucode_rom
    import ucode_pkg::*;
#(
    parameter int ADDR_W = ucode_pkg::UAW
) (
    input  logic [ADDR_W-1:0] addr,
    output uword_t            word
);
    localparam int DEPTH = 1 << ADDR_W;

    uword_t rom [DEPTH];

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_word
            assign rom[i] = uword_at(UAW'(i));
        end
    endgenerate

    assign word = rom[addr];
endmodule

// File: rtl/ucode_dispatch.sv
module ucode_dispatch
    import ucode_pkg::*;
#(
    parameter int OP_W     = ucode_pkg::OPW,
    parameter int ADDR_W   = ucode_pkg::UAW,
    parameter int TABLE_ID = 1
) (
    input  logic [OP_W-1:0]   opcode,
    output logic [ADDR_W-1:0] target,
    output logic              hit
);
    generate
        if (TABLE_ID == 1) begin : g_tab1
            always_comb begin
                hit    = 1'b1;
                target = ADDR_W'(U_FETCH);
                case (opcode)
                    OP_RTYPE: target = ADDR_W'(U_REXEC);
                    OP_LOAD,
                    OP_STORE: target = ADDR_W'(U_MADDR);
                    OP_BEQ:   target = ADDR_W'(U_BRANCH);
                    default:  hit    = 1'b0;
                endcase
            end
        end else begin : g_tab2
            always_comb begin
                hit    = 1'b1;
                target = ADDR_W'(U_FETCH);
                case (opcode)
                    OP_LOAD:  target = ADDR_W'(U_LDMEM);
                    OP_STORE: target = ADDR_W'(U_STMEM);
                    default:  hit    = 1'b0;
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/ucode_next.sv
module ucode_next
    import ucode_pkg::*;
#(
    parameter int ADDR_W = ucode_pkg::UAW
) (
    input  logic [ADDR_W-1:0] cur,
    input  seq_mode_e         mode,
    input  logic [ADDR_W-1:0] d1_target,
    input  logic              d1_hit,
    input  logic [ADDR_W-1:0] d2_target,
    input  logic              d2_hit,
    output logic [ADDR_W-1:0] nxt,
    output logic              miss
);
    always_comb begin
        nxt  = '0;
        miss = 1'b0;
        unique case (mode)
            SQ_FETCH: nxt = '0;
            SQ_NEXT:  nxt = cur + 1'b1;
            SQ_DISP1: begin
                nxt  = d1_hit ? d1_target : '0;
                miss = !d1_hit;
            end
            SQ_DISP2: begin
                nxt  = d2_hit ? d2_target : '0;
                miss = !d2_hit;
            end
        endcase
    end
endmodule

// File: rtl/ucode_seq.sv
module ucode_seq
    import ucode_pkg::*;
#(
    parameter int OP_W   = ucode_pkg::OPW,
    parameter int ADDR_W = ucode_pkg::UAW,
    parameter int CTRL_W = ucode_pkg::CW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [OP_W-1:0]   opcode,
    output logic [CTRL_W-1:0] ctrl,
    output logic [ADDR_W-1:0] uaddr,
    output logic              illegal_op
);
    ustep_e            state_q;
    logic              illegal_q;
    uword_t            word;
    logic [ADDR_W-1:0] nxt;
    logic              miss;

    logic [ADDR_W-1:0] tgt [2];
    logic              hit [2];

    ucode_rom #(.ADDR_W(ADDR_W)) rom_i (
        .addr (state_q),
        .word (word)
    );

    generate
        for (genvar t = 0; t < 2; t++) begin : g_disp
            ucode_dispatch #(
                .OP_W     (OP_W),
                .ADDR_W   (ADDR_W),
                .TABLE_ID (t + 1)
            ) disp_i (
                .opcode (opcode),
                .target (tgt[t]),
                .hit    (hit[t])
            );
        end
    endgenerate

    ucode_next #(.ADDR_W(ADDR_W)) next_i (
        .cur       (state_q),
        .mode      (word.seq),
        .d1_target (tgt[0]),
        .d1_hit    (hit[0]),
        .d2_target (tgt[1]),
        .d2_hit    (hit[1]),
        .nxt       (nxt),
        .miss      (miss)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= U_FETCH;
            illegal_q <= 1'b0;
        end else begin
            state_q <= ustep_e'(nxt);
            if (miss) begin
                illegal_q <= 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        ctrl       = word.ctrl;
        uaddr      = state_q;
        illegal_op = illegal_q;
    end

    // R1
    reset_to_fetch_chk: assert property (@(posedge clk)
        rst |=> (state_q == U_FETCH) && !illegal_q);

    // R4
    seq_increment_chk: assert property (@(posedge clk) disable iff (rst)
        (word.seq == SQ_NEXT) |=> (uaddr == ADDR_W'($past(uaddr) + 1'b1)));

    // R5
    fetch_return_chk: assert property (@(posedge clk) disable iff (rst)
        (word.seq == SQ_FETCH) |=> (state_q == U_FETCH));

    // R8
    miss_to_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        miss |=> (state_q == U_FETCH) && illegal_q);

    // R8
    illegal_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        illegal_q |=> illegal_q);

    // R2
    mem_rw_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ctrl[12], ctrl[11]}));
endmodule

// File: tb/ucode_seq_tb_top.sv
module ucode_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  opcode = 6'h00;
    logic [15:0] ctrl;
    logic [3:0]  uaddr;
    logic        illegal_op;

    int total = 0;
    int fail  = 0;

    always #2.5 clk = ~clk;

    ucode_seq dut_i (
        .clk        (clk),
        .rst        (rst),
        .opcode     (opcode),
        .ctrl       (ctrl),
        .uaddr      (uaddr),
        .illegal_op (illegal_op)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Expected control words from the bit layout in R2 and R3
    function automatic logic [15:0] exp_word(input logic [3:0] a);
        case (a)
            4'd0: return (16'd1 << 15) | (16'd1 << 12) | (16'd1 << 10) | (16'd1 << 3);
            4'd1: return (16'd3 << 3);
            4'd2: return (16'd1 << 2) | (16'd2 << 3);
            4'd3: return (16'd1 << 13) | (16'd1 << 12);
            4'd4: return (16'd1 << 9) | (16'd1 << 1);
            4'd5: return (16'd1 << 13) | (16'd1 << 11);
            4'd6: return (16'd1 << 2) | (16'd2 << 5);
            4'd7: return (16'd1 << 1) | 16'd1;
            4'd8: return (16'd1 << 14) | (16'd1 << 2) | (16'd1 << 5) | (16'd1 << 7);
            default: return 16'd0;
        endcase
    endfunction

    // 0 fetch, 1 table 1, 2 table 2, 3 step
    function automatic int exp_mode(input logic [3:0] a);
        case (a)
            4'd0, 4'd3, 4'd6: return 3;
            4'd1: return 1;
            4'd2: return 2;
            default: return 0;
        endcase
    endfunction

    function automatic int tab1(input logic [5:0] op);
        case (op)
            6'h00: return 6;
            6'h23, 6'h2B: return 2;
            6'h04: return 8;
            default: return -1;
        endcase
    endfunction

    function automatic int tab2(input logic [5:0] op);
        case (op)
            6'h23: return 3;
            6'h2B: return 5;
            default: return -1;
        endcase
    endfunction

    function automatic int exp_len(input logic [5:0] op);
        case (op)
            6'h23: return 5;
            6'h2B, 6'h00: return 4;
            6'h04: return 3;
            default: return 2;
        endcase
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        opcode = 6'h00;
        @(negedge clk);
        chk("R1 uaddr", 32'(uaddr), 32'd0);
        chk("R1 illegal", 32'(illegal_op), 32'd0);
        chk("R1 ctrl", 32'(ctrl), 32'h9408);
        rst = 1'b0;
    endtask

    // Walk one instruction from address 0 back to address 0
    task automatic run_op(input logic [5:0] op);
        logic [3:0] ea = 4'd0;
        logic       ei = 1'b0;
        string      tag = "R1";
        do_reset();
        opcode = op;
        for (int s = 0; s < 10; s++) begin
            chk({tag, " uaddr"}, 32'(uaddr), 32'(ea));
            chk((ea == 4'd0) ? "R2 ctrl" : "R3 ctrl", 32'(ctrl), 32'(exp_word(ea)));
            chk("R8 illegal", 32'(illegal_op), 32'(ei));
            if (s > 0 && ea == 4'd0) begin
                chk("R9 length", 32'(s), 32'(exp_len(op)));
                break;
            end
            case (exp_mode(ea))
                3: begin ea = ea + 4'd1; tag = "R4"; end
                1: begin
                    if (tab1(op) < 0) begin ea = 4'd0; ei = 1'b1; tag = "R8"; end
                    else begin ea = 4'(tab1(op)); tag = "R6"; end
                end
                2: begin
                    if (tab2(op) < 0) begin ea = 4'd0; ei = 1'b1; tag = "R8"; end
                    else begin ea = 4'(tab2(op)); tag = "R7"; end
                end
                default: begin ea = 4'd0; tag = "R5"; end
            endcase
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fail, total);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        // Every opcode, each after its own reset
        for (int op = 0; op < 64; op++) begin
            run_op(6'(op));
        end

        // R7 / R8: table 2 miss when the opcode changes after decode
        do_reset();
        opcode = 6'h23;
        @(posedge clk); @(negedge clk);
        chk("R4 uaddr", 32'(uaddr), 32'd1);
        @(posedge clk); @(negedge clk);
        chk("R6 uaddr", 32'(uaddr), 32'd2);
        opcode = 6'h04;
        @(posedge clk); @(negedge clk);
        chk("R8 uaddr", 32'(uaddr), 32'd0);
        chk("R8 illegal", 32'(illegal_op), 32'd1);
        @(posedge clk); @(negedge clk);
        chk("R4 uaddr", 32'(uaddr), 32'd1);
        chk("R8 sticky", 32'(illegal_op), 32'd1);
        @(posedge clk); @(negedge clk);
        chk("R6 uaddr", 32'(uaddr), 32'd8);
        chk("R3 ctrl", 32'(ctrl), 32'h40A4);
        chk("R8 sticky", 32'(illegal_op), 32'd1);

        // R1: reset clears the sticky flag
        do_reset();

        summary();
        $finish;
    end
endmodule